// File: doc/BRIEF.md
# Receive Descriptor Fill Engine

This block is the device-side receive path of a network adapter. Host software hands over empty receive buffers by writing their byte offsets into a post register. The engine queues the offsets in a free-descriptor FIFO. When a frame arrives on the MAC-side byte stream, the engine takes the oldest free offset. It then writes the frame bytes, one per cycle, into that descriptor's payload area through a byte-wide memory write port.

Once the last byte has been stored, the engine writes the 12-bit length into the descriptor header. Only after that does it set the received flag, which returns the descriptor to the host. A frame that finds no free descriptor is discarded whole. A frame longer than the payload area is cut to fit. A set of event counters can be read by the host and cleared by writing zero to them. A flush input discards every posted offset.

The descriptor is laid out as follows:
- Header: 24 bytes.
- Received word: byte offset 4; bit 0 is the received flag.
- Length field: little-endian 16-bit value at byte offset 16.
- Payload: starts at byte offset 24.

Top module: `rxd_fill_engine`

## Requirements
- R1: A cycle with `post_we` high and `post_data[31]` = 1 queues `post_data[OFFS_W-1:0]` as a free descriptor offset. A post with bit 31 = 0, or a post while `FIFO_DEPTH` offsets are already queued, is ignored.
- R2: Free descriptors are used in posting order. Byte k of a stored frame is written to address offset+24+k. The write appears on the memory port one cycle after the byte is accepted.
- R3: After the last byte of a stored frame, exactly three writes follow on consecutive cycles, in this order:
  - offset+16: the length low byte;
  - offset+17: the length high byte;
  - offset+4: the value 0x01 (received flag).
  The length is 24 + stored bytes + 4.
- R4: If no free descriptor is queued when the first byte of a frame arrives, the whole frame causes no memory write and the dropped counter (select 4) increments once.
- R5: Bytes beyond `PAYLOAD_BYTES` (default 2024) are not written. The reported length is then 28 + `PAYLOAD_BYTES`, the receive-error counter (select 1) increments once, and the flag is still set.
- R6: The counters are read on `cnt_rdata` by `cnt_sel`:
  - select 0: frame errors, counting `rx_frame_err` on a last byte;
  - select 2: CRC errors, counting `rx_crc_err` on a last byte;
  - select 3: link-lost events, one per cycle with `link_lost` high;
  - select 5: received frames, one per descriptor whose flag has been written.
- R7: A `cnt_we` cycle with `cnt_wdata` = 0 clears the selected counter, and this clear wins over an increment in the same cycle. A non-zero write has no effect.
- R8: The 8-bit event counters (selects 0 to 4) stop at 255. The received-frame counter is 32 bits wide and wraps.
- R9: A `free_flush` cycle discards all queued offsets, including a post made in the same cycle.
- R10: During reset the FIFO is empty, all counters read 0 and `mem_we` is low.
- R11: After the last byte of a stored frame the source keeps `rx_valid` low for at least three cycles, so the header write-back is not overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_we | input | 1 | Post register write strobe |
| post_data | input | 32 | Bit 31 valid, low bits descriptor offset |
| free_flush | input | 1 | Discard all queued free offsets |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Last byte of frame |
| rx_crc_err | input | 1 | CRC error, sampled with the last byte |
| rx_frame_err | input | 1 | Framing error, sampled with the last byte |
| link_lost | input | 1 | Link-lost event pulse |
| cnt_sel | input | 3 | Counter select |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 32 | Counter write data (zero clears) |
| cnt_rdata | output | 32 | Selected counter value |
| mem_we | output | 1 | Buffer memory byte write enable |
| mem_addr | output | OFFS_W | Buffer memory byte address |
| mem_wdata | output | 8 | Buffer memory write byte |

## Verification
The scoreboard predicts every memory write, so a design that set the flag before the length would show a write order mismatch. A one-byte frame tests the case where the first and last byte arrive together; a design that lost the descriptor there would write to a stale offset or never write back. An oversize frame tests truncation, which a wrong design would show as writes past the payload area or a length above 2052. The bench also covers:
- flushing the FIFO;
- overfilling the FIFO with 65 posts, where a design that wrapped its count would reuse an offset;
- saturating a counter, where a wrapping design would read a small value;
- a clear that arrives in the same cycle as an increment.

// File: rtl/rxd_fill_pkg.sv
package rxd_fill_pkg;
   localparam int HDR_BYTES     = 24;
   localparam int FCS_BYTES     = 4;
   localparam int RECV_WORD_OFS = 4;
   localparam int LEN_FIELD_OFS = 16;
   localparam int LEN_BITS      = 12;
   localparam int NUM_CNT       = 6;
   localparam int SEL_FRAME_ERR = 0;
   localparam int SEL_RX_ERR    = 1;
   localparam int SEL_CRC_ERR   = 2;
   localparam int SEL_LINK_LOST = 3;
   localparam int SEL_DROPPED   = 4;
   localparam int SEL_RX_FRAMES = 5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FILL,
      ST_DROP,
      ST_LEN_LO,
      ST_LEN_HI,
      ST_FLAG
   } fill_st_e;
endpackage

// File: rtl/rxd_free_fifo.sv
module rxd_free_fifo #(
   parameter int DEPTH = 64,
   parameter int W     = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic         empty,
   output logic         full,
   output logic [W-1:0] head
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("rxd_free_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  slots [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [AW:0]   count;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == (AW+1)'(DEPTH));
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign head    = slots[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) slots[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty) else $error("flush left descriptors queued"); // R9
   AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty) else $error("pop with no free descriptor"); // R4
endmodule

// File: rtl/rxd_evt_counter.sv
module rxd_evt_counter #(
   parameter int W   = 8,
   parameter bit SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] q
);
   generate
      if (W < 1 || W > 32) begin : g_bad_width
         $error("rxd_evt_counter: W must be 1..32");
      end
      if (SAT) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n || clr)        q <= '0;
            else if (inc && q != '1)  q <= q + 1'b1;
         end
         AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
            (q == '1 && !clr) |=> (q == '1)) else $error("counter wrapped"); // R8
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n || clr) q <= '0;
            else if (inc)      q <= q + 1'b1;
         end
      end
   endgenerate

   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0)) else $error("clear did not win"); // R7
endmodule

// File: rtl/rxd_fill_ctrl.sv
module rxd_fill_ctrl
   import rxd_fill_pkg::*;
#(
   parameter int OFFS_W        = 24,
   parameter int PAYLOAD_BYTES = 2024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_last,
   input  logic              rx_crc_err,
   input  logic              rx_frame_err,
   input  logic              fifo_empty,
   input  logic [OFFS_W-1:0] fifo_head,
   output logic              fifo_pop,
   output logic              mem_we,
   output logic [OFFS_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              inc_drop,
   output logic              inc_rxerr,
   output logic              inc_crc,
   output logic              inc_ferr,
   output logic              inc_frames
);
   localparam int IW      = $clog2(PAYLOAD_BYTES + 1);
   localparam int MAX_LEN = HDR_BYTES + PAYLOAD_BYTES + FCS_BYTES;

   generate
      if (MAX_LEN >= (1 << LEN_BITS)) begin : g_bad_payload
         $error("rxd_fill_ctrl: payload too large for the 12-bit length field");
      end
      if (OFFS_W < LEN_BITS) begin : g_bad_offs
         $error("rxd_fill_ctrl: OFFS_W too narrow for one descriptor");
      end
   endgenerate

   fill_st_e          st_q;
   logic [OFFS_W-1:0] base_q, cur_base;
   logic [IW-1:0]     idx_q, idx_c, stored_next;
   logic              trunc_q, trunc_c;
   logic              start, store_start, store_byte, room, wr_byte, accept_last;
   logic [LEN_BITS-1:0] len_val;

   assign start       = rx_valid && (st_q == ST_IDLE);
   assign store_start = start && !fifo_empty;
   assign store_byte  = store_start || (rx_valid && st_q == ST_FILL);
   assign cur_base    = store_start ? fifo_head : base_q;
   assign idx_c       = store_start ? '0 : idx_q;
   assign room        = idx_c < IW'(PAYLOAD_BYTES);
   assign wr_byte     = store_byte && room;
   assign trunc_c     = (store_start ? 1'b0 : trunc_q) | (store_byte && !room);
   assign stored_next = idx_c + IW'(wr_byte);
   assign accept_last = rx_valid && rx_last &&
                        (st_q == ST_IDLE || st_q == ST_FILL || st_q == ST_DROP);
   assign len_val     = LEN_BITS'(HDR_BYTES + FCS_BYTES) + LEN_BITS'(idx_q);

   assign fifo_pop    = store_start;
   assign inc_drop    = start && fifo_empty;
   assign inc_crc     = accept_last && rx_crc_err;
   assign inc_ferr    = accept_last && rx_frame_err;
   assign inc_rxerr   = store_byte && rx_last && trunc_c;
   assign inc_frames  = (st_q == ST_FLAG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         base_q  <= '0;
         idx_q   <= '0;
         trunc_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               if (fifo_empty) begin
                  st_q <= rx_last ? ST_IDLE : ST_DROP;
               end else begin
                  base_q  <= fifo_head;
                  idx_q   <= stored_next;
                  trunc_q <= trunc_c;
                  st_q    <= rx_last ? ST_LEN_LO : ST_FILL;
               end
            end
            ST_FILL: if (rx_valid) begin
               idx_q   <= stored_next;
               trunc_q <= trunc_c;
               if (rx_last) st_q <= ST_LEN_LO;
            end
            ST_DROP:   if (rx_valid && rx_last) st_q <= ST_IDLE;
            ST_LEN_LO: st_q <= ST_LEN_HI;
            ST_LEN_HI: st_q <= ST_FLAG;
            default:   st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= wr_byte || st_q == ST_LEN_LO || st_q == ST_LEN_HI || st_q == ST_FLAG;
         if (wr_byte) begin
            mem_addr  <= cur_base + OFFS_W'(HDR_BYTES) + OFFS_W'(idx_c);
            mem_wdata <= rx_data;
         end else if (st_q == ST_LEN_LO) begin
            mem_addr  <= base_q + OFFS_W'(LEN_FIELD_OFS);
            mem_wdata <= len_val[7:0];
         end else if (st_q == ST_LEN_HI) begin
            mem_addr  <= base_q + OFFS_W'(LEN_FIELD_OFS + 1);
            mem_wdata <= 8'(len_val[LEN_BITS-1:8]);
         end else if (st_q == ST_FLAG) begin
            mem_addr  <= base_q + OFFS_W'(RECV_WORD_OFS);
            mem_wdata <= 8'h01;
         end
      end
   end

   AST_INPUT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LEN_LO || st_q == ST_LEN_HI || st_q == ST_FLAG) |-> !rx_valid)
      else $error("byte arrived during header write-back"); // R11
   AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DROP) |=> !mem_we) else $error("dropped frame wrote memory"); // R4
   AST_WRITE_IN_DESC: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (OFFS_W'(mem_addr - base_q) < OFFS_W'(HDR_BYTES + PAYLOAD_BYTES)))
      else $error("write outside descriptor"); // R5
endmodule

// File: rtl/rxd_fill_engine.sv
module rxd_fill_engine
   import rxd_fill_pkg::*;
#(
   parameter int OFFS_W        = 24,
   parameter int FIFO_DEPTH    = 64,
   parameter int PAYLOAD_BYTES = 2024,
   parameter int EVT_CNT_W     = 8,
   parameter int FRM_CNT_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              post_we,
   input  logic [31:0]       post_data,
   input  logic              free_flush,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_last,
   input  logic              rx_crc_err,
   input  logic              rx_frame_err,
   input  logic              link_lost,
   input  logic [2:0]        cnt_sel,
   input  logic              cnt_we,
   input  logic [31:0]       cnt_wdata,
   output logic [31:0]       cnt_rdata,
   output logic              mem_we,
   output logic [OFFS_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata
);
   generate
      if (OFFS_W > 30) begin : g_bad_offs
         $error("rxd_fill_engine: OFFS_W must leave bit 31 for the valid flag");
      end
      if (FRM_CNT_W > 32 || EVT_CNT_W > 32) begin : g_bad_cnt
         $error("rxd_fill_engine: counters are limited to 32 bits");
      end
   endgenerate

   logic              fifo_empty, fifo_full, fifo_pop, post_push;
   logic [OFFS_W-1:0] fifo_head;
   logic              unused_post_hi;
   logic [NUM_CNT-1:0] cnt_inc, cnt_clr;
   logic [31:0]       cnt_val [NUM_CNT];

   assign post_push      = post_we && post_data[31];
   assign unused_post_hi = ^{post_data[30:OFFS_W], fifo_full};

   rxd_free_fifo #(.DEPTH(FIFO_DEPTH), .W(OFFS_W)) u_free (
      .clk(clk), .rst_n(rst_n), .flush(free_flush),
      .push(post_push), .push_data(post_data[OFFS_W-1:0]),
      .pop(fifo_pop), .empty(fifo_empty), .full(fifo_full), .head(fifo_head)
   );

   rxd_fill_ctrl #(.OFFS_W(OFFS_W), .PAYLOAD_BYTES(PAYLOAD_BYTES)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
      .rx_crc_err(rx_crc_err), .rx_frame_err(rx_frame_err),
      .fifo_empty(fifo_empty), .fifo_head(fifo_head), .fifo_pop(fifo_pop),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .inc_drop(cnt_inc[SEL_DROPPED]), .inc_rxerr(cnt_inc[SEL_RX_ERR]),
      .inc_crc(cnt_inc[SEL_CRC_ERR]), .inc_ferr(cnt_inc[SEL_FRAME_ERR]),
      .inc_frames(cnt_inc[SEL_RX_FRAMES])
   );

   assign cnt_inc[SEL_LINK_LOST] = link_lost;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
         localparam int  CW  = (gi == SEL_RX_FRAMES) ? FRM_CNT_W : EVT_CNT_W;
         localparam bit  SAT = (gi != SEL_RX_FRAMES);
         logic [CW-1:0] q;
         assign cnt_clr[gi] = cnt_we && (cnt_wdata == 32'd0) && (cnt_sel == 3'(gi));
         rxd_evt_counter #(.W(CW), .SAT(SAT)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(cnt_inc[gi]), .clr(cnt_clr[gi]), .q(q)
         );
         assign cnt_val[gi] = 32'(q);
      end
   endgenerate

   always_comb begin
      cnt_rdata = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (cnt_sel == 3'(i)) cnt_rdata = cnt_val[i];
      end
   end
endmodule

// File: tb/rxd_fill_engine_bench.sv
module rxd_fill_engine_bench;
   localparam int PL = 2024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        post_we = 1'b0;
   logic [31:0] post_data = '0;
   logic        free_flush = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_last = 1'b0;
   logic        rx_crc_err = 1'b0;
   logic        rx_frame_err = 1'b0;
   logic        link_lost = 1'b0;
   logic [2:0]  cnt_sel = '0;
   logic        cnt_we = 1'b0;
   logic [31:0] cnt_wdata = '0;
   logic [31:0] cnt_rdata;
   logic        mem_we;
   logic [23:0] mem_addr;
   logic [7:0]  mem_wdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [23:0] addr;
      logic [7:0]  data;
      string       req;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   rxd_fill_engine u_rxd_fill_engine (
      .clk(clk), .rst_n(rst_n), .post_we(post_we), .post_data(post_data),
      .free_flush(free_flush), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_last(rx_last), .rx_crc_err(rx_crc_err), .rx_frame_err(rx_frame_err),
      .link_lost(link_lost), .cnt_sel(cnt_sel), .cnt_we(cnt_we),
      .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   // monitor: every memory write must match the oldest prediction
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL R4 unexpected write addr=%h data=%h expected no write", mem_addr, mem_wdata);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (mem_addr !== e.addr || mem_wdata !== e.data) begin
               errors++;
               $display("FAIL %s write addr=%h data=%h expected addr=%h data=%h",
                        e.req, mem_addr, mem_wdata, e.addr, e.data);
            end
         end
      end
   end

   task automatic push_exp(input logic [23:0] a, input logic [7:0] d, input string req);
      exp_t e;
      e.addr = a; e.data = d; e.req = req;
      sb.push_back(e);
   endtask

   task automatic post(input logic [31:0] v);
      post_we = 1'b1; post_data = v;
      @(negedge clk);
      post_we = 1'b0;
   endtask

   task automatic send_frame(input int n, input bit store, input logic [23:0] base,
                             input bit crc, input bit ferr, input logic [7:0] seed,
                             input string lreq);
      int stored;
      logic [11:0] len;
      stored = (n > PL) ? PL : n;
      len = 12'(28 + stored);
      if (store) begin
         for (int k = 0; k < stored; k++) push_exp(base + 24'(24 + k), seed + 8'(k), "R2");
         push_exp(base + 24'd16, len[7:0], lreq);
         push_exp(base + 24'd17, {4'h0, len[11:8]}, lreq);
         push_exp(base + 24'd4, 8'h01, "R3");
      end
      for (int k = 0; k < n; k++) begin
         rx_valid = 1'b1; rx_data = seed + 8'(k); rx_last = (k == n - 1);
         rx_crc_err = (k == n - 1) && crc; rx_frame_err = (k == n - 1) && ferr;
         @(negedge clk);
      end
      rx_valid = 1'b0; rx_last = 1'b0; rx_crc_err = 1'b0; rx_frame_err = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic chk_cnt(input logic [2:0] sel, input logic [31:0] exp, input string req);
      cnt_sel = sel;
      #1;
      checks++;
      if (cnt_rdata !== exp) begin
         errors++;
         $display("FAIL %s counter %0d = %0d expected %0d", req, sel, cnt_rdata, exp);
      end
   endtask

   task automatic cnt_write(input logic [2:0] sel, input logic [31:0] v);
      cnt_sel = sel; cnt_we = 1'b1; cnt_wdata = v;
      @(negedge clk);
      cnt_we = 1'b0;
   endtask

   task automatic chk_sb_empty(input string req);
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL %s %0d predicted writes missing expected 0", req, sb.size());
         sb.delete();
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      checks++;
      if (mem_we !== 1'b0) begin
         errors++;
         $display("FAIL R10 mem_we=%b expected 0", mem_we);
      end
      for (int s = 0; s < 6; s++) chk_cnt(3'(s), 0, "R10");
      rst_n = 1'b1;
      @(negedge clk);

      // R1: three valid posts, one with bit 31 clear
      post(32'h8000_0000);
      post(32'h8000_0800);
      post(32'h8000_1000);
      post(32'h0000_2000);
      send_frame(5, 1, 24'h000000, 0, 0, 8'h10, "R3");
      send_frame(1, 1, 24'h000800, 0, 0, 8'hA5, "R3");
      send_frame(60, 1, 24'h001000, 1, 0, 8'h40, "R3");
      send_frame(7, 0, 24'h0, 0, 0, 8'h00, "R4");       // R4: no descriptor left
      chk_sb_empty("R4");
      chk_cnt(4, 1, "R4");
      chk_cnt(2, 1, "R6");
      chk_cnt(5, 3, "R6");

      post(32'h8000_3000);
      send_frame(9, 1, 24'h003000, 0, 1, 8'h77, "R3");
      chk_cnt(0, 1, "R6");
      chk_cnt(5, 4, "R6");

      // R7: non-zero write ignored, zero clears
      cnt_write(5, 32'h1);
      chk_cnt(5, 4, "R7");
      cnt_write(5, 32'h0);
      chk_cnt(5, 0, "R7");

      // R9: flush discards posted descriptors
      post(32'h8000_4000);
      post(32'h8000_4800);
      free_flush = 1'b1; post_we = 1'b1; post_data = 32'h8000_5000;
      @(negedge clk);
      free_flush = 1'b0; post_we = 1'b0;
      send_frame(4, 0, 24'h0, 0, 0, 8'h00, "R9");
      chk_sb_empty("R9");
      chk_cnt(4, 2, "R9");

      // R5: oversize frame truncated
      post(32'h8001_0000);
      send_frame(PL + 6, 1, 24'h010000, 0, 0, 8'h03, "R5");
      chk_sb_empty("R5");
      chk_cnt(1, 1, "R5");
      chk_cnt(5, 1, "R5");

      // R1/R2: fill FIFO past depth, order preserved, 65th post ignored
      for (int i = 0; i < 65; i++) post(32'h8000_0000 | 32'(i * 32'h800));
      for (int i = 0; i < 64; i++) send_frame(1, 1, 24'(i * 32'h800), 0, 0, 8'(i), "R3");
      send_frame(1, 0, 24'h0, 0, 0, 8'h00, "R1");
      chk_sb_empty("R1");
      chk_cnt(4, 3, "R1");
      chk_cnt(5, 65, "R2");

      // R8: saturation of an 8-bit counter
      link_lost = 1'b1;
      repeat (260) @(negedge clk);
      link_lost = 1'b0;
      chk_cnt(3, 255, "R8");
      // R7: clear wins over a same-cycle increment
      link_lost = 1'b1;
      cnt_write(3, 32'h0);
      link_lost = 1'b0;
      chk_cnt(3, 0, "R7");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule